// File: doc/BRIEF.md
# Single-Byte Buffered Serial Port

This block is a small asynchronous serial port with a 32-bit word-addressed register window. It has one transmit holding byte and one receive holding byte. It sends and receives a fixed frame: one start bit, eight data bits least significant bit first, and one stop bit. There is no parity and no flow control.

The bit period is a whole number of system clock cycles taken directly from a 21-bit divisor register. There is no oversampling prescaler. Status and interrupt flags latch their events. Software clears them by writing ones. A lost byte in either direction raises an overrun flag.

Four interrupt outputs are provided: transmit, receive, overrun, and an OR of those three. They let the block be wired to separate request lines or to one shared line. Software writes bytes into the data register while the transmit buffer is free. It drains received bytes by reading the same register.

Top module: `byte_uart`

## Requirements
- R1: After reset, all flags and the control register are zero, the divisor register reads 16, the serial output is high and every interrupt output is low.
- R2: The registers are at these byte offsets: data 0x00, status 0x04, control 0x08, interrupt 0x0C and divisor 0x10. Control keeps bits 5:0 and the divisor keeps bits 20:0. Upper bits read as zero, and any other offset reads zero.
- R3: A data write made while the transmit-full flag (status bit 0) is clear stores the byte and sets that flag.
- R4: A data write made while status bit 0 is set is dropped and sets the transmit-overrun flag (status bit 2, interrupt bit 2). The byte already held is the one transmitted later.
- R5: With transmit enable (control bit 0) set and the shifter idle, the held byte moves into the shifter. This clears status bit 0 and sets interrupt bit 0. The line then carries a low start bit, eight data bits LSB first and a high stop bit. While transmit enable is clear the byte stays held.
- R6: With receive enable (control bit 1) set, a received frame stores its byte and sets status bit 1 and interrupt bit 1. Reading data returns the byte and clears status bit 1.
- R7: A low pulse shorter than half a bit period does not start a reception. A low stop bit is accepted without error.
- R8: A byte that completes while status bit 1 is still set is discarded. It sets the receive-overrun flag (status bit 3, interrupt bit 3), and the earlier byte stays readable.
- R9: Writing a 1 to an interrupt bit clears that flag, and writing 0 leaves it unchanged. Writing a 1 to status bit 2 or 3 clears that overrun flag. When a new event and a clear fall in the same cycle, the event wins.
- R10: The interrupt outputs follow the flags and the control enables:
  - `irqTx` = interrupt bit 0 AND control bit 2.
  - `irqRx` = interrupt bit 1 AND control bit 3.
  - `irqOvr` = (interrupt bit 2 AND control bit 4) OR (interrupt bit 3 AND control bit 5).
  - `irqAny` is the OR of the three outputs above.
- R11: Every serial bit, in both directions, lasts exactly as many clock cycles as the divisor register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| regSel | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 5 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| rxLine | input | 1 | Serial input, idles high |
| txLine | output | 1 | Serial output, idles high |
| irqTx | output | 1 | Transmit buffer freed, masked |
| irqRx | output | 1 | Byte received, masked |
| irqOvr | output | 1 | Either overrun, masked |
| irqAny | output | 1 | OR of the three interrupts |

## Verification
The embedded assertions watch, on every cycle, the cause-and-effect steps between control and datapath:
- an accepted write fills the buffer;
- a refused write latches the overrun flag;
- a load frees the buffer, drives the start bit and latches the transmit flag;
- an overrun leaves the stored receive byte untouched.

Only the bench scenarios can show that whole frames are correct. That covers bit order and bit duration at two divisors, glitch rejection, acceptance of a low stop bit, the write-one-to-clear behaviour seen through the registers, and round trips of random bytes through loopback at random divisors.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

  // Word index of each register (byte offset / 4)
  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_STATE = 3'd1,
    REG_CTRL  = 3'd2,
    REG_INT   = 3'd3,
    REG_DIV   = 3'd4
  } regIdx_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic       txEn;
    logic       rxEn;
    logic [7:0] txByte;
  } strobe_t;

  // Datapath -> control status and events
  typedef struct packed {
    logic       txFull;
    logic       rxFull;
    logic       txLoaded;
    logic       rxDone;
    logic [7:0] rxByte;
  } status_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rxState_t;

endpackage

// File: rtl/byte_uart_ctrl.sv
module byte_uart_ctrl
  import byte_uart_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DIV_W     = 21,
  parameter int DIV_RESET = 16,
  parameter int CTRL_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  status_t           st,
  output strobe_t           stb,
  output logic [DIV_W-1:0]  baudDiv,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqOvr,
  output logic              irqAny
);

  localparam int IDX_W = ADDR_W - 2;

  logic [CTRL_W-1:0] ctrlReg;
  logic txIntF, rxIntF, txOvrF, rxOvrF;
  logic hitData, hitState, hitCtrl, hitInt, hitDiv, aligned;
  logic wrData, rdData, wrState, wrCtrl, wrInt, wrDiv;
  logic txOvrSet, rxOvrSet;
  logic [3:0] intClr;
  logic [1:0] ovrClrState;
  logic unusedBits;

  assign unusedBits = ^regWdata[31:DIV_W];

  assign aligned  = (regAddr[1:0] == 2'b00);
  assign hitData  = aligned && regAddr[ADDR_W-1:2] == IDX_W'(REG_DATA);
  assign hitState = aligned && regAddr[ADDR_W-1:2] == IDX_W'(REG_STATE);
  assign hitCtrl  = aligned && regAddr[ADDR_W-1:2] == IDX_W'(REG_CTRL);
  assign hitInt   = aligned && regAddr[ADDR_W-1:2] == IDX_W'(REG_INT);
  assign hitDiv   = aligned && regAddr[ADDR_W-1:2] == IDX_W'(REG_DIV);

  assign wrData  = regSel && regWrite && hitData;
  assign rdData  = regSel && !regWrite && hitData;
  assign wrState = regSel && regWrite && hitState;
  assign wrCtrl  = regSel && regWrite && hitCtrl;
  assign wrInt   = regSel && regWrite && hitInt;
  assign wrDiv   = regSel && regWrite && hitDiv;

  always_comb begin
    stb.txPush = wrData && !st.txFull;
    stb.rxPop  = rdData && st.rxFull;
    stb.txEn   = ctrlReg[0];
    stb.rxEn   = ctrlReg[1];
    stb.txByte = regWdata[7:0];
  end

  assign txOvrSet    = wrData && st.txFull;
  assign rxOvrSet    = st.rxDone && st.rxFull && !stb.rxPop;
  assign intClr      = wrInt ? regWdata[3:0] : 4'b0;
  assign ovrClrState = wrState ? regWdata[3:2] : 2'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      baudDiv <= DIV_W'(DIV_RESET);
      txIntF  <= 1'b0;
      rxIntF  <= 1'b0;
      txOvrF  <= 1'b0;
      rxOvrF  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWdata[CTRL_W-1:0];
      if (wrDiv)  baudDiv <= regWdata[DIV_W-1:0];
      // events take priority over clears
      txIntF <= st.txLoaded || (txIntF && !intClr[0]);
      rxIntF <= (st.rxDone && (!st.rxFull || stb.rxPop)) || (rxIntF && !intClr[1]);
      txOvrF <= txOvrSet || (txOvrF && !intClr[2] && !ovrClrState[0]);
      rxOvrF <= rxOvrSet || (rxOvrF && !intClr[3] && !ovrClrState[1]);
    end
  end

  always_comb begin
    regRdata = '0;
    if (hitData)  regRdata = {24'b0, st.rxByte};
    if (hitState) regRdata = {28'b0, rxOvrF, txOvrF, st.rxFull, st.txFull};
    if (hitCtrl)  regRdata = {{(32-CTRL_W){1'b0}}, ctrlReg};
    if (hitInt)   regRdata = {28'b0, rxOvrF, txOvrF, rxIntF, txIntF};
    if (hitDiv)   regRdata = {{(32-DIV_W){1'b0}}, baudDiv};
  end

  assign irqTx  = txIntF && ctrlReg[2];
  assign irqRx  = rxIntF && ctrlReg[3];
  assign irqOvr = (txOvrF && ctrlReg[4]) || (rxOvrF && ctrlReg[5]);
  assign irqAny = irqTx || irqRx || irqOvr;

  // R4: refused write latches transmit overrun
  a_r4_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && st.txFull) |=> txOvrF);

  // R9: load event sets the transmit flag even against a same-cycle clear
  a_r9_load_sets_txint: assert property (@(posedge clk) disable iff (!rstN)
    st.txLoaded |=> txIntF);

  // R8: a discarded byte always raises receive overrun
  a_r8_drop_sets_rxovr: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxDone && st.rxFull && !stb.rxPop) |=> rxOvrF);

endmodule

// File: rtl/byte_uart_dp.sv
module byte_uart_dp
  import byte_uart_pkg::*;
#(
  parameter int DIV_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             rxLine,
  output logic             txLine,
  output status_t          st
);

  localparam int FRAME_BITS = 10;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

  // ---------------- transmit ----------------
  logic [7:0]            txHold;
  logic                  txFull, txBusy, txLoad;
  logic [FRAME_BITS-1:0] txShift;
  logic [BIT_CNT_W-1:0]  txBit;
  logic [DIV_W-1:0]      txCnt;

  assign txLoad = txFull && !txBusy && stb.txEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      txFull  <= 1'b0;
      txBusy  <= 1'b0;
      txShift <= '1;
      txBit   <= '0;
      txCnt   <= '0;
    end else begin
      if (stb.txPush) begin
        txHold <= stb.txByte;
        txFull <= 1'b1;
      end
      if (txLoad) begin
        txFull  <= 1'b0;
        txBusy  <= 1'b1;
        txShift <= {1'b1, txHold, 1'b0};
        txBit   <= BIT_CNT_W'(FRAME_BITS - 1);
        txCnt   <= baudDiv - DIV_W'(1);
      end else if (txBusy) begin
        if (txCnt == '0) begin
          if (txBit == '0) begin
            txBusy <= 1'b0;
          end else begin
            txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
            txBit   <= txBit - BIT_CNT_W'(1);
            txCnt   <= baudDiv - DIV_W'(1);
          end
        end else begin
          txCnt <= txCnt - DIV_W'(1);
        end
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // ---------------- receive ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxCur, rxPrev;
  rxState_t               rxState;
  logic [DIV_W-1:0]       rxCnt;
  logic [3:0]             rxIdx;
  logic [7:0]             rxShift, rxData;
  logic                   rxFull, rxDone;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate

  assign rxCur  = syncQ[SYNC_STAGES-1];
  assign rxDone = (rxState == RX_BITS) && stb.rxEn && (rxCnt == '0) && (rxIdx == 4'd8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPrev  <= 1'b1;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else begin
      rxPrev <= rxCur;
      case (rxState)
        RX_IDLE: begin
          if (stb.rxEn && rxPrev && !rxCur) begin
            rxState <= RX_START;
            rxCnt   <= (baudDiv >> 1) - DIV_W'(1);
          end
        end
        RX_START: begin
          if (!stb.rxEn) rxState <= RX_IDLE;
          else if (rxCnt == '0) begin
            if (!rxCur) begin
              rxState <= RX_BITS;
              rxCnt   <= baudDiv - DIV_W'(1);
              rxIdx   <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end else rxCnt <= rxCnt - DIV_W'(1);
        end
        RX_BITS: begin
          if (!stb.rxEn) rxState <= RX_IDLE;
          else if (rxCnt == '0) begin
            if (rxIdx == 4'd8) begin
              rxState <= RX_IDLE;  // stop bit value is not checked
            end else begin
              rxShift <= {rxCur, rxShift[7:1]};
              rxIdx   <= rxIdx + 4'd1;
              rxCnt   <= baudDiv - DIV_W'(1);
            end
          end else rxCnt <= rxCnt - DIV_W'(1);
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
    end else if (rxDone && (!rxFull || stb.rxPop)) begin
      rxData <= rxShift;
      rxFull <= 1'b1;
    end else if (stb.rxPop) begin
      rxFull <= 1'b0;
    end
  end

  always_comb begin
    st.txFull   = txFull;
    st.rxFull   = rxFull;
    st.txLoaded = txLoad;
    st.rxDone   = rxDone;
    st.rxByte   = rxData;
  end

  // R3: accepted write fills the transmit buffer
  a_r3_push_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPush |=> txFull);

  // R5: a load frees the buffer and drives the start bit
  a_r5_load_starts_frame: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> (!txFull && txBusy && !txLine));

  // R8: overrun leaves the stored byte untouched
  a_r8_keep_old_byte: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxFull && !stb.rxPop) |=> (rxFull && $stable(rxData)));

endmodule

// File: rtl/byte_uart.sv
module byte_uart
  import byte_uart_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 21,
  parameter int DIV_RESET   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              rxLine,
  output logic              txLine,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqOvr,
  output logic              irqAny
);

  strobe_t          stb;
  status_t          st;
  logic [DIV_W-1:0] baudDiv;

  byte_uart_ctrl #(
    .ADDR_W   (ADDR_W),
    .DIV_W    (DIV_W),
    .DIV_RESET(DIV_RESET),
    .CTRL_W   (6)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regSel  (regSel),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .st      (st),
    .stb     (stb),
    .baudDiv (baudDiv),
    .irqTx   (irqTx),
    .irqRx   (irqRx),
    .irqOvr  (irqOvr),
    .irqAny  (irqAny)
  );

  byte_uart_dp #(
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .baudDiv(baudDiv),
    .rxLine (rxLine),
    .txLine (txLine),
    .st     (st)
  );

endmodule

// File: tb/test_byte_uart.sv
module test_byte_uart;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrite = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rxDrv = 1'b1;
  logic        loopEn = 1'b0;
  logic        rxLine, txLine, irqTx, irqRx, irqOvr, irqAny;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_DATA = 5'h00, A_STATE = 5'h04, A_CTRL = 5'h08,
                         A_INT = 5'h0C, A_DIV = 5'h10;

  always #5 clk = ~clk;

  assign rxLine = loopEn ? txLine : rxDrv;

  byte_uart i_byte_uart (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .rxLine(rxLine), .txLine(txLine), .irqTx(irqTx), .irqRx(irqRx),
    .irqOvr(irqOvr), .irqAny(irqAny)
  );

  function automatic logic [3:0] expIrq(logic [5:0] c, logic [3:0] f);
    logic t, r, o;
    t = f[0] & c[2];
    r = f[1] & c[3];
    o = (f[2] & c[4]) | (f[3] & c[5]);
    return {t | r | o, o, r, t};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regSel = 1'b0;
  endtask

  // capture one frame from txLine, sampling at bit centres
  task automatic grabFrame(int div, output logic [7:0] b, output bit okFrame);
    int waitN = 0;
    okFrame = 1'b1;
    b = '0;
    while (txLine === 1'b1 && waitN < 2000) begin
      @(negedge clk);
      waitN++;
    end
    repeat (div / 2) @(negedge clk);
    if (txLine !== 1'b0) okFrame = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (div) @(negedge clk);
      b[i] = txLine;
    end
    repeat (div) @(negedge clk);
    if (txLine !== 1'b1) okFrame = 1'b0;
  endtask

  task automatic sendFrame(int div, logic [7:0] b, logic stopBit);
    @(negedge clk);
    rxDrv = 1'b0;
    repeat (div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxDrv = b[i];
      repeat (div) @(negedge clk);
    end
    rxDrv = stopBit;
    repeat (div) @(negedge clk);
    rxDrv = 1'b1;
    repeat (div) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    bit          ok;
    int          div;
    int unsigned seedDummy;

    seedDummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(A_STATE, d); chk("R1 state", d, 0);
    regRd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    regRd(A_INT, d);   chk("R1 int", d, 0);
    regRd(A_DIV, d);   chk("R1 div", d, 16);
    chk("R1 txLine", {31'b0, txLine}, 1);
    chk("R1 irqs", {28'b0, irqAny, irqOvr, irqRx, irqTx}, 0);

    // R2 register map and widths
    regWr(A_CTRL, 32'hFFFF_FFFF);
    regRd(A_CTRL, d); chk("R2 ctrl width", d, 32'h3F);
    regWr(A_DIV, 32'hFFFF_FFFF);
    regRd(A_DIV, d);  chk("R2 div width", d, 32'h1F_FFFF);
    regRd(5'h14, d);  chk("R2 unmapped", d, 0);
    regWr(A_CTRL, 0);
    regWr(A_DIV, 16);

    // R3 / R4 with transmitter disabled
    regWr(A_DATA, 32'hA5);
    regRd(A_STATE, d); chk("R3 tx full", d, 32'h1);
    regWr(A_DATA, 32'h3C);
    regRd(A_STATE, d); chk("R4 tx overrun state", d, 32'h5);
    regRd(A_INT, d);   chk("R4 tx overrun int", d, 32'h4);
    regWr(A_CTRL, 32'h10);
    chk("R10 ovr irq", {28'b0, irqAny, irqOvr, irqRx, irqTx}, {28'b0, expIrq(6'h10, 4'h4)});
    regWr(A_INT, 32'h0);
    regRd(A_INT, d);   chk("R9 write zero keeps", d, 32'h4);
    regWr(A_STATE, 32'h4);
    regRd(A_STATE, d); chk("R9 state w1c", d, 32'h1);
    chk("R10 ovr irq cleared", {31'b0, irqOvr}, 0);

    // R5 transmit held byte, 0x3C was dropped
    regWr(A_CTRL, 32'h05);
    grabFrame(16, b, ok);
    chk("R5 frame byte", {24'b0, b}, 32'hA5);
    chk("R5 frame shape", {31'b0, ok}, 1);
    regRd(A_STATE, d); chk("R5 buffer freed", d, 0);
    regRd(A_INT, d);   chk("R5 tx flag", d, 32'h1);
    chk("R10 tx irq", {28'b0, irqAny, irqOvr, irqRx, irqTx}, {28'b0, expIrq(6'h05, 4'h1)});
    regWr(A_INT, 32'h1);
    chk("R9 tx irq cleared", {31'b0, irqTx}, 0);

    // R11 other divisor
    regWr(A_DIV, 37);
    regWr(A_DATA, 32'h5A);
    grabFrame(37, b, ok);
    chk("R11 frame byte div37", {24'b0, b}, 32'h5A);
    chk("R11 frame shape div37", {31'b0, ok}, 1);
    regWr(A_INT, 32'hF);

    // R6 receive
    regWr(A_CTRL, 32'h0A);
    sendFrame(37, 8'hC3, 1'b1);
    regRd(A_STATE, d); chk("R6 rx full", d, 32'h2);
    chk("R10 rx irq", {31'b0, irqRx}, 1);
    regRd(A_DATA, d);  chk("R6 rx byte", d, 32'hC3);
    regRd(A_STATE, d); chk("R6 rx popped", d, 0);
    regWr(A_INT, 32'h2);

    // R7 glitch rejection and low stop bit
    @(negedge clk); rxDrv = 1'b0;
    repeat (6) @(negedge clk); rxDrv = 1'b1;
    repeat (100) @(negedge clk);
    regRd(A_STATE, d); chk("R7 glitch ignored", d, 0);
    sendFrame(37, 8'h81, 1'b0);
    regRd(A_STATE, d); chk("R7 low stop accepted", d, 32'h2);
    regRd(A_DATA, d);  chk("R7 low stop byte", d, 32'h81);

    // R8 receive overrun
    sendFrame(37, 8'h11, 1'b1);
    sendFrame(37, 8'h22, 1'b1);
    regRd(A_STATE, d); chk("R8 overrun state", d, 32'hA);
    regWr(A_CTRL, 32'h2A);
    chk("R10 rx ovr irq", {28'b0, irqAny, irqOvr, irqRx, irqTx}, {28'b0, expIrq(6'h2A, 4'hA)});
    regRd(A_DATA, d);  chk("R8 old byte kept", d, 32'h11);
    regWr(A_INT, 32'h8);
    regRd(A_INT, d);   chk("R9 int w1c rx ovr", d, 32'h2);
    regWr(A_INT, 32'h2);

    // random loopback round trips (R5, R6, R11)
    loopEn = 1'b1;
    regWr(A_CTRL, 32'h03);
    for (int k = 0; k < 16; k++) begin
      div = 16 + int'($urandom % 25);
      b = 8'($urandom);
      regWr(A_DIV, div);
      regWr(A_DATA, {24'b0, b});
      repeat (10 * div + 12) @(negedge clk);
      regRd(A_STATE, d); chk("R6 loop rx full", d & 32'h3, 32'h2);
      regRd(A_DATA, d);  chk("R11 loop byte", d, {24'b0, b});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule